// File: doc/BRIEF.md
# Legacy Keyboard Port Emulation Registers

This block sits inside a host controller and stands in for the old keyboard controller interface. It holds four 32-bit registers: control, input, output and status. Software reads and writes all four through a memory-mapped register window. Once emulation is switched on, the block also answers I/O reads and writes to the legacy data port (60h) and command/status port (64h).

The two access paths reach the same storage but behave differently. Legacy I/O accesses move the full and command/data flags in the status register. Memory-mapped accesses never touch those flags, so a service routine can inspect and refill the registers freely.

Every claimed I/O access latches a sticky pending bit. That bit drives an emulation event output, which wakes the service routine. The routine then handles the keystroke or command and clears the pending bit.

Top module: `kbe_legacy_emu`

## Requirements
- R1: After reset, all four registers read 0, `emu_evt` is 0, and no I/O access is claimed.
- R2: The registers sit at byte offsets 100h (control), 104h (input), 108h (output) and 10Ch (status), all 32 bits wide. Reads return the register value. Writes replace all 32 bits, except control bit 1, which follows R9. An address outside these four word-aligned offsets, including a misaligned one such as 101h, reads 0 and changes nothing.
- R3: `io_hit` is high in the same cycle as `io_stb` only when control bit 0 is 1 and `io_port` equals 60h or 64h. An unclaimed access returns `io_rdata` = 0 and leaves every register unchanged.
- R4: A claimed read of port 60h returns bits 7:0 of the output register on `io_rdata` and clears status bit 0 (output full).
- R5: A claimed write to port 60h stores `io_wdata` into input bits 7:0, sets status bit 1 (input full) and clears status bit 3 (command/data).
- R6: A claimed write to port 64h stores `io_wdata` into input bits 7:0, clears status bit 1 and sets status bit 3.
- R7: A claimed read of port 64h returns status bits 7:0 on `io_rdata` and changes no register other than control bit 1.
- R8: Memory-mapped reads and writes have no side effect on any status flag. A status write lands exactly as written, and a read of the output register leaves status bit 0 as it was.
- R9: Control bit 1 is a pending flag. It is set by every claimed I/O access and cleared by a memory write of 1 to that bit; a write of 0 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins. `emu_evt` equals this bit.
- R10: When a memory write and a claimed I/O access land in the same cycle, the memory write is applied first. The I/O side effects then override only the bits they touch: status bits 0, 1 and 3, and input bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_vld | input | 1 | Register bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset into the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| io_stb | input | 1 | Legacy I/O access strobe |
| io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| io_port | input | 16 | Legacy I/O port number |
| io_wdata | input | 8 | I/O write byte |
| io_hit | output | 1 | Access claimed, same cycle |
| io_rdata | output | 8 | I/O read byte, same cycle |
| emu_evt | output | 1 | Emulation event, equals pending flag |

## Verification
The bench aims at the places where the two access paths meet:
- **Same-cycle memory write and claimed I/O access.** A design that let the memory write win would lose the flag change made by the port access.
- **Same-cycle pending clear and claimed access.** A design that let the clear win would drop an event.
- **Port 60h read after a memory read of the output register.** A design that put side effects on the memory path would clear output full too early.
- **Accesses while emulation is off, and near-miss ports and offsets (61h, 65h, 101h, 110h).** A loose decoder would claim these or corrupt a register.

// File: rtl/kbe_pkg.sv
package kbe_pkg;

   typedef enum logic [1:0] {
      KR_CTRL = 2'd0,
      KR_IN   = 2'd1,
      KR_OUT  = 2'd2,
      KR_STAT = 2'd3
   } kbe_reg_e;

   localparam int NUM_REGS = 4;

   // status flag positions (decoded by legacy software)
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_CMD = 3;

   // control bit positions
   localparam int CT_EN   = 0;
   localparam int CT_PEND = 1;

   localparam int IO_BYTE_W = 8;

   typedef struct packed {
      logic hit;
      logic wr;
      logic data_port;
   } kbe_io_t;

endpackage

// File: rtl/kbe_reg_dec.sv
module kbe_reg_dec #(
   parameter int ADDR_W   = 12,
   parameter int BASE_OFS = 'h100
) (
   input  logic                         vld,
   input  logic [ADDR_W-1:0]            addr,
   output logic [kbe_pkg::NUM_REGS-1:0] sel,
   output logic                         any
);
   localparam int            IDX_W = $clog2(kbe_pkg::NUM_REGS);
   localparam int            LOW_W = IDX_W + 2;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_OFS);

   if (ADDR_W <= LOW_W) begin : g_bad_aw
      $error("kbe_reg_dec: ADDR_W too small");
   end
   if ((BASE_OFS % (4 * kbe_pkg::NUM_REGS)) != 0) begin : g_bad_base
      $error("kbe_reg_dec: BASE_OFS must be aligned to the window size");
   end

   logic in_win;
   logic aligned;

   always_comb begin
      in_win  = (addr[ADDR_W-1:LOW_W] == BASE_V[ADDR_W-1:LOW_W]);
      aligned = (addr[1:0] == 2'b00);
   end

   for (genvar i = 0; i < kbe_pkg::NUM_REGS; i++) begin : g_sel
      always_comb begin
         sel[i] = vld && in_win && aligned && (addr[LOW_W-1:2] == IDX_W'(i));
      end
   end

   assign any = |sel;

endmodule

// File: rtl/kbe_port_dec.sv
module kbe_port_dec #(
   parameter int PORT_W    = 16,
   parameter int DATA_PORT = 'h60,
   parameter int CMD_PORT  = 'h64
) (
   input  logic              stb,
   input  logic              wr,
   input  logic [PORT_W-1:0] port,
   input  logic              en,
   output kbe_pkg::kbe_io_t  acc
);
   localparam logic [PORT_W-1:0] DP = PORT_W'(DATA_PORT);
   localparam logic [PORT_W-1:0] CP = PORT_W'(CMD_PORT);

   if (PORT_W < 8) begin : g_bad_pw
      $error("kbe_port_dec: PORT_W too small");
   end
   if (DATA_PORT == CMD_PORT) begin : g_bad_ports
      $error("kbe_port_dec: ports must differ");
   end
   if (DATA_PORT >= (1 << PORT_W) || CMD_PORT >= (1 << PORT_W)) begin : g_bad_range
      $error("kbe_port_dec: port number exceeds PORT_W");
   end

   logic is_dp;
   logic is_cp;

   always_comb begin
      is_dp         = (port == DP);
      is_cp         = (port == CP);
      acc.hit       = stb && en && (is_dp || is_cp);
      acc.wr        = wr;
      acc.data_port = is_dp;
   end

endmodule

// File: rtl/kbe_flag_ctl.sv
module kbe_flag_ctl #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_wdata,
   input  kbe_pkg::kbe_io_t  io,
   output logic [DATA_W-1:0] stat_q
);
   import kbe_pkg::*;

   if (DATA_W < 8) begin : g_bad_dw
      $error("kbe_flag_ctl: DATA_W must hold a byte");
   end

   logic [DATA_W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (mem_we) stat_d = mem_wdata;
      if (io.hit) begin
         if (io.wr) begin
            stat_d[ST_IBF] = io.data_port;
            stat_d[ST_CMD] = !io.data_port;
         end else if (io.data_port) begin
            stat_d[ST_OBF] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assert_obf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io.hit && !io.wr && io.data_port) |=> !stat_q[ST_OBF]);

   assert_wr_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io.hit && io.wr && io.data_port) |=> (stat_q[ST_IBF] && !stat_q[ST_CMD]));

   assert_wr_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io.hit && io.wr && !io.data_port) |=> (!stat_q[ST_IBF] && stat_q[ST_CMD]));

   assert_stat_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io.hit && !io.wr && !io.data_port && !mem_we) |=> $stable(stat_q));

   assert_mem_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !io.hit) |=> (stat_q == $past(mem_wdata)));

   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we && !io.hit) |=> $stable(stat_q));

endmodule

// File: rtl/kbe_evt_ctl.sv
module kbe_evt_ctl #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_wdata,
   input  logic              io_claim,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              evt
);
   import kbe_pkg::*;

   if (DATA_W <= CT_PEND) begin : g_bad_dw
      $error("kbe_evt_ctl: DATA_W too small");
   end

   logic [DATA_W-1:0] ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (mem_we) begin
         ctrl_d          = mem_wdata;
         ctrl_d[CT_PEND] = ctrl_q[CT_PEND] && !mem_wdata[CT_PEND];
      end
      if (io_claim) ctrl_d[CT_PEND] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   assign evt = ctrl_q[CT_PEND];

   assert_evt_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_claim |=> evt);

   assert_evt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !(mem_we && mem_wdata[CT_PEND])) |=> evt);

   assert_evt_nospur_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt && !io_claim) |=> !evt);

endmodule

// File: rtl/kbe_legacy_emu.sv
module kbe_legacy_emu #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int PORT_W    = 16,
   parameter int BASE_OFS  = 'h100,
   parameter int DATA_PORT = 'h60,
   parameter int CMD_PORT  = 'h64,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_vld,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              io_stb,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] io_port,
   input  logic [7:0]        io_wdata,
   output logic              io_hit,
   output logic [7:0]        io_rdata,
   output logic              emu_evt
);
   import kbe_pkg::*;

   if (DATA_W < IO_BYTE_W) begin : g_bad_dw
      $error("kbe_legacy_emu: DATA_W must hold a byte");
   end

   logic [NUM_REGS-1:0] sel;
   logic                sel_any;
   logic [NUM_REGS-1:0] we;
   kbe_io_t             io;
   logic [DATA_W-1:0]   ctrl_q;
   logic [DATA_W-1:0]   in_q;
   logic [DATA_W-1:0]   out_q;
   logic [DATA_W-1:0]   stat_q;
   logic [DATA_W-1:0]   in_d;
   logic [DATA_W-1:0]   rd_mux;

   kbe_reg_dec #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)) u_rdec (
      .vld  (reg_vld),
      .addr (reg_addr),
      .sel  (sel),
      .any  (sel_any)
   );

   assign we = sel & {NUM_REGS{reg_wr}};

   kbe_port_dec #(.PORT_W(PORT_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_pdec (
      .stb  (io_stb),
      .wr   (io_wr),
      .port (io_port),
      .en   (ctrl_q[CT_EN]),
      .acc  (io)
   );

   kbe_evt_ctl #(.DATA_W(DATA_W)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_we    (we[KR_CTRL]),
      .mem_wdata (reg_wdata),
      .io_claim  (io.hit),
      .ctrl_q    (ctrl_q),
      .evt       (emu_evt)
   );

   kbe_flag_ctl #(.DATA_W(DATA_W)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_we    (we[KR_STAT]),
      .mem_wdata (reg_wdata),
      .io        (io),
      .stat_q    (stat_q)
   );

   always_comb begin
      in_d = in_q;
      if (we[KR_IN]) in_d = reg_wdata;
      if (io.hit && io.wr) in_d[IO_BYTE_W-1:0] = io_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= '0;
         out_q <= '0;
      end else begin
         in_q <= in_d;
         if (we[KR_OUT]) out_q <= reg_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (reg_vld && !reg_wr && sel_any) begin
         unique case (1'b1)
            sel[KR_CTRL]: rd_mux = ctrl_q;
            sel[KR_IN]:   rd_mux = in_q;
            sel[KR_OUT]:  rd_mux = out_q;
            sel[KR_STAT]: rd_mux = stat_q;
            default:      rd_mux = '0;
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) reg_rdata <= '0;
         else        reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end

   assign io_hit = io.hit;

   always_comb begin
      io_rdata = '0;
      if (io.hit && !io.wr) begin
         io_rdata = io.data_port ? out_q[IO_BYTE_W-1:0] : stat_q[IO_BYTE_W-1:0];
      end
   end

   assert_in_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io.hit && io.wr) |=> (in_q[IO_BYTE_W-1:0] == $past(io_wdata)));

   assert_unclaimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_stb && !io.hit && !reg_vld) |=> ($stable(in_q) && $stable(stat_q) && $stable(out_q)));

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: tb/sim_kbe_legacy_emu.sv
module sim_kbe_legacy_emu;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_vld, reg_wr;
   logic [11:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        io_stb, io_wr;
   logic [15:0] io_port;
   logic [7:0]  io_wdata, io_rdata;
   logic        io_hit, emu_evt;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model of the four registers
   logic [31:0] m_ctrl, m_in, m_out, m_st;

   always #10 clk = ~clk;

   kbe_legacy_emu u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_vld(reg_vld), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .io_stb(io_stb), .io_wr(io_wr), .io_port(io_port), .io_wdata(io_wdata),
      .io_hit(io_hit), .io_rdata(io_rdata), .emu_evt(emu_evt)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int map_idx(logic [11:0] a);
      if (a == 12'h100) return 0;
      if (a == 12'h104) return 1;
      if (a == 12'h108) return 2;
      if (a == 12'h10C) return 3;
      return -1;
   endfunction

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      case (map_idx(a))
         0: return m_ctrl;
         1: return m_in;
         2: return m_out;
         3: return m_st;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_hit(bit s, logic [15:0] p);
      return s && m_ctrl[0] && (p == 16'h60 || p == 16'h64);
   endfunction

   // one bus cycle; expectations from the model, then model update
   task automatic step(string tag, bit mv, bit mw, logic [11:0] ma, logic [31:0] md,
                       bit is, bit iw, logic [15:0] ip, logic [7:0] id);
      bit h;
      @(negedge clk);
      reg_vld = mv; reg_wr = mw; reg_addr = ma; reg_wdata = md;
      io_stb = is; io_wr = iw; io_port = ip; io_wdata = id;
      #2;
      h = exp_hit(is, ip);
      check({tag, " R3 io_hit"}, {31'b0, io_hit}, {31'b0, h});
      if (h && !iw)
         check({tag, " R4/R7 io_rdata"}, {24'b0, io_rdata},
               {24'b0, (ip == 16'h60) ? m_out[7:0] : m_st[7:0]});
      else
         check({tag, " R3 io_rdata idle"}, {24'b0, io_rdata}, 32'h0);
      if (mv && !mw) check({tag, " R2 reg_rdata"}, reg_rdata, exp_rd(ma));
      @(posedge clk);
      if (mv && mw) begin
         case (map_idx(ma))
            0: m_ctrl = {md[31:2], m_ctrl[1] & ~md[1], md[0]};
            1: m_in   = md;
            2: m_out  = md;
            3: m_st   = md;
            default: ;
         endcase
      end
      if (h) begin
         m_ctrl[1] = 1'b1;
         if (iw) begin
            m_in[7:0] = id;
            m_st[1] = (ip == 16'h60);
            m_st[3] = (ip != 16'h60);
         end else if (ip == 16'h60) begin
            m_st[0] = 1'b0;
         end
      end
      #2;
      check({tag, " R9 emu_evt"}, {31'b0, emu_evt}, {31'b0, m_ctrl[1]});
   endtask

   task automatic mwr(string tag, logic [11:0] a, logic [31:0] d);
      step(tag, 1, 1, a, d, 0, 0, 16'h0, 8'h0);
   endtask
   task automatic mrd(string tag, logic [11:0] a);
      step(tag, 1, 0, a, 32'h0, 0, 0, 16'h0, 8'h0);
   endtask
   task automatic ioa(string tag, bit w, logic [15:0] p, logic [7:0] d);
      step(tag, 0, 0, 12'h0, 32'h0, 1, w, p, d);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] addrs [8];
      logic [15:0] ports [6];
      addrs = '{12'h100, 12'h104, 12'h108, 12'h10C, 12'h110, 12'h101, 12'h0FC, 12'h10E};
      ports = '{16'h60, 16'h64, 16'h61, 16'h65, 16'h160, 16'h0};
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      reg_vld = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
      io_stb = 0; io_wr = 0; io_port = '0; io_wdata = '0;
      m_ctrl = '0; m_in = '0; m_out = '0; m_st = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state through the register window
      mrd("R1 ctrl", 12'h100);
      mrd("R1 in",   12'h104);
      mrd("R1 out",  12'h108);
      mrd("R1 stat", 12'h10C);

      // R3: emulation off, accesses not claimed and no side effects
      ioa("R3 off wr60", 1, 16'h60, 8'h77);
      ioa("R3 off rd64", 0, 16'h64, 8'h00);
      mrd("R3 off in", 12'h104);
      mrd("R3 off stat", 12'h10C);

      mwr("R2 enable", 12'h100, 32'h0000_0001);
      mwr("R2 out", 12'h108, 32'h1234_56A5);
      mwr("R8 stat", 12'h10C, 32'h0000_0001);
      mrd("R8 out rd", 12'h108);
      mrd("R8 stat after out rd", 12'h10C);
      ioa("R3 near 61", 0, 16'h61, 8'h0);
      ioa("R7 rd64", 0, 16'h64, 8'h0);
      mrd("R7 stat", 12'h10C);
      ioa("R4 rd60", 0, 16'h60, 8'h0);
      mrd("R4 stat", 12'h10C);
      ioa("R5 wr60", 1, 16'h60, 8'h3C);
      mrd("R5 in", 12'h104);
      mrd("R5 stat", 12'h10C);
      mwr("R9 clear0", 12'h100, 32'h0000_0001);
      mwr("R9 clear1", 12'h100, 32'h0000_0003);
      ioa("R6 wr64", 1, 16'h64, 8'hD4);
      mrd("R6 stat", 12'h10C);
      mrd("R6 in", 12'h104);
      // R10: simultaneous memory write to status and port 64h write
      step("R10 same cycle", 1, 1, 12'h10C, 32'hFFFF_FFFF, 1, 1, 16'h64, 8'h11);
      mrd("R10 stat", 12'h10C);
      step("R10 in same cycle", 1, 1, 12'h104, 32'hAAAA_AAAA, 1, 1, 16'h60, 8'h5B);
      mrd("R10 in", 12'h104);
      // R9: clear and set in the same cycle, set wins
      step("R9 set wins", 1, 1, 12'h100, 32'h0000_0003, 1, 0, 16'h64, 8'h0);
      mrd("R9 ctrl", 12'h100);
      // R2: unmapped and misaligned offsets
      mwr("R2 unmapped", 12'h110, 32'hDEAD_BEEF);
      mwr("R2 misaligned", 12'h101, 32'hDEAD_BEEF);
      mrd("R2 unmapped rd", 12'h110);
      mrd("R2 all ctrl", 12'h100);
      mrd("R2 all out", 12'h108);

      // constrained random mix
      for (int i = 0; i < 800; i++) begin
         bit mv, mw, is, iw;
         logic [31:0] d;
         logic [11:0] a;
         logic [15:0] p;
         mv = ($urandom % 3) != 0;
         mw = $urandom % 2;
         is = ($urandom % 2);
         iw = $urandom % 2;
         a  = addrs[$urandom % 8];
         p  = ports[$urandom % 6];
         d  = $urandom;
         if (a == 12'h100 && ($urandom % 4) != 0) d[0] = 1'b1;
         step("RND", mv, mw, a, d, is, iw, p, 8'($urandom));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule